// File: doc/BRIEF.md
# Adaptive Sequential Prefetch Controller

This block decides how much a bridge's read line buffer prefetches from a slow target bus on behalf of a master issuing dword reads. It watches each dword request against the span of data already fetched and reports a hit. It also watches a burst hint from the master. It issues one fetch command at a time, each with a start address and a byte count. The depth of prefetch adapts while the block runs. A sequential-access flag selects 16-byte half-line fetches when it is clear and 32-byte full-line fetches when it is set.

The flag is cleared whenever a new read starts. It is set in two ways: the burst hint seen while the first fetch of a read is still outstanding, or a request for the dword that follows the previous one within buffered data. It is cleared by a jump inside the buffered data, by a miss while data is held, and by the burst hint falling. The buffered data is thrown away when a memory write or an I/O write runs on the target bus. The data store itself and the bus engines sit outside this block.

Top module: `seq_prefetch_ctrl`

## Requirements
- R1: After reset `fetch_req`, `seq_flag` and `req_hit` are all 0.
- R2: A request while no data is held and no fetch is outstanding starts a new read. The flag is cleared and, one clock later, a fetch is raised at the request address. Its length runs to the next 16-byte boundary (16 minus address bits [3:0]).
- R3: `fetch_req` stays high with a stable `fetch_addr` until `fetch_ack` is seen. Only one fetch is outstanding at a time. After the acknowledge, requests for addresses in [first fetched address, end of fetched data) report `req_hit` = 1 in the same cycle.
- R4: If `burst_hint` is high at a clock edge while the first fetch of a read is still outstanding, the flag is set one clock later. The outstanding fetch's length grows to the next 32-byte boundary (32 minus address bits [4:0]).
- R5: A hit whose address equals the previous request address plus 4, seen while the flag is clear, sets the flag one clock later. It also raises one full-line fetch at the end of the fetched data two clocks after the request, sized to the next 32-byte boundary.
- R6: A `line_free` pulse raises a fetch at the end of the fetched data two clocks later. The fetch is sized to the 32-byte boundary when the flag is set and to the 16-byte boundary when it is clear.
- R7: A hit that is neither the previous address nor the previous address plus 4 clears the flag one clock later.
- R8: A request that misses while data is held clears the flag and discards the data. `req_hit` then reads 0 for formerly held addresses, and the next request starts a new read as in R2.
- R9: A high-to-low change of `burst_hint` clears the flag one clock later.
- R10: A target-bus cycle with `cyc_kind` 1 (memory write) or 3 (I/O write) discards the held data. Kinds 0 (memory read), 2 (I/O read), 4 (interrupt acknowledge), 5 (configuration) and 6 (ownership change) leave `req_hit` unchanged.
- R11: A request for an address covered by the outstanding fetch is neither a hit nor a miss. It leaves the fetch and the held data in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master dword read request present |
| req_addr | input | AW | Dword-aligned request byte address |
| req_hit | output | 1 | Request falls inside fetched data (combinational) |
| burst_hint | input | 1 | Master signals a burst |
| line_free | input | 1 | A 32-byte line of buffer space became free (pulse) |
| cyc_valid | input | 1 | Target-bus cycle observed this clock |
| cyc_kind | input | 3 | Kind of that cycle (see R10) |
| fetch_req | output | 1 | Fetch command outstanding |
| fetch_addr | output | AW | Start byte address of the fetch |
| fetch_len | output | 6 | Byte count of the fetch |
| fetch_ack | input | 1 | Target completed the outstanding fetch |
| seq_flag | output | 1 | Sequential-access flag (1 = full-line mode) |

## Verification
`req_hit` is combinational, so the bench drives a request just after a falling edge and samples it 1 ns later, before any rising edge. Flag changes, the new-read fetch and the burst extension appear one rising edge after the stimulus edge, and the bench checks them at the next falling edge. Fetches triggered by a sequential hit or by `line_free` pass through a registered trigger first. The bench therefore waits a second falling edge before it checks their address and length. Invalidation is observed through `req_hit` on an address that hit just before.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int HALF_BYTES = 16;
    localparam int FULL_BYTES = 32;
    localparam int LEN_W      = 6;

    typedef enum logic [2:0] {
        CYC_MEM_RD = 3'd0,
        CYC_MEM_WR = 3'd1,
        CYC_IO_RD  = 3'd2,
        CYC_IO_WR  = 3'd3,
        CYC_INTA   = 3'd4,
        CYC_CFG    = 3'd5,
        CYC_OWNER  = 3'd6,
        CYC_RSVD   = 3'd7
    } cyc_kind_e;

    typedef struct packed {
        logic hit;
        logic seq;
        logic same;
        logic ooo;
        logic miss;
    } req_class_t;

    function automatic logic [LEN_W-1:0] span_to_boundary(logic [4:0] low, logic full);
        if (full)
            return LEN_W'(FULL_BYTES - int'(low));
        else
            return LEN_W'(HALF_BYTES - int'(low[3:0]));
    endfunction

    function automatic logic is_write_cycle(logic [2:0] kind);
        return (kind == CYC_MEM_WR) || (kind == CYC_IO_WR);
    endfunction

endpackage

// File: rtl/spc_classify.sv
module spc_classify
    import spc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    req_addr,
    input  logic             buf_valid,
    input  logic [AW-1:0]    win_base,
    input  logic [AW-1:0]    win_end,
    input  logic [AW-1:0]    last_addr,
    input  logic             pend,
    input  logic             drop,
    input  logic [AW-1:0]    pend_addr,
    input  logic [LEN_W-1:0] pend_len,
    output req_class_t       cls
);
    localparam int PAD = AW - LEN_W;

    logic          in_buf;
    logic          in_flight;
    logic [AW-1:0] flight_end;

    assign flight_end = pend_addr + {{PAD{1'b0}}, pend_len};
    assign in_buf     = buf_valid && (req_addr >= win_base) && (req_addr < win_end);
    assign in_flight  = pend && !drop && (req_addr >= pend_addr) && (req_addr < flight_end);

    always_comb begin
        cls.hit  = in_buf;
        cls.seq  = in_buf && (req_addr == last_addr + AW'(4));
        cls.same = in_buf && (req_addr == last_addr);
        cls.ooo  = in_buf && !cls.seq && !cls.same;
        cls.miss = buf_valid && !in_buf && !in_flight;
    end
endmodule

// File: rtl/spc_flag.sv
module spc_flag (
    input  logic clk,
    input  logic rst,
    input  logic new_read,
    input  logic ooo_evt,
    input  logic miss_evt,
    input  logic seq_evt,
    input  logic burst_hint,
    input  logic first_pending,
    output logic seq_flag,
    output logic flag_nxt,
    output logic extend_evt,
    output logic hit_set_evt
);
    logic burst_q;
    logic burst_fall;

    assign burst_fall = burst_q && !burst_hint;

    always_comb begin
        flag_nxt    = seq_flag;
        extend_evt  = 1'b0;
        hit_set_evt = 1'b0;
        if (new_read) begin
            flag_nxt = 1'b0;
        end else if (ooo_evt || miss_evt || burst_fall) begin
            flag_nxt = 1'b0;
        end else if (burst_hint && first_pending) begin
            flag_nxt   = 1'b1;
            extend_evt = 1'b1;
        end else if (seq_evt && !seq_flag) begin
            flag_nxt    = 1'b1;
            hit_set_evt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_flag <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            seq_flag <= flag_nxt;
            burst_q  <= burst_hint;
        end
    end
endmodule

// File: rtl/seq_prefetch_ctrl.sv
module seq_prefetch_ctrl
    import spc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_hit,
    input  logic             burst_hint,
    input  logic             line_free,
    input  logic             cyc_valid,
    input  logic [2:0]       cyc_kind,
    output logic             fetch_req,
    output logic [AW-1:0]    fetch_addr,
    output logic [LEN_W-1:0] fetch_len,
    input  logic             fetch_ack,
    output logic             seq_flag
);
    localparam int PAD = AW - LEN_W;

    logic             buf_valid, pend, pend_full, first_q, drop, want_line, free_q;
    logic [AW-1:0]    win_base, win_end, last_addr, pend_addr;
    logic [LEN_W-1:0] pend_len;
    req_class_t       cls;

    logic inval_now, act, new_read, seq_evt, ooo_evt, miss_evt, issue;
    logic flag_nxt, extend_evt, hit_set_evt, first_pending;

    assign pend_len      = span_to_boundary(pend_addr[4:0], pend_full);
    assign inval_now     = cyc_valid && is_write_cycle(cyc_kind);
    assign act           = req_valid && !inval_now;
    assign new_read      = act && !buf_valid && !pend;
    assign seq_evt       = act && cls.seq;
    assign ooo_evt       = act && cls.ooo;
    assign miss_evt      = act && cls.miss;
    assign first_pending = pend && first_q && !drop;
    assign issue         = !pend && buf_valid && !miss_evt && !inval_now && (free_q || want_line);

    spc_classify #(.AW(AW)) u_classify (
        .req_addr (req_addr),
        .buf_valid(buf_valid),
        .win_base (win_base),
        .win_end  (win_end),
        .last_addr(last_addr),
        .pend     (pend),
        .drop     (drop),
        .pend_addr(pend_addr),
        .pend_len (pend_len),
        .cls      (cls)
    );

    spc_flag u_flag (
        .clk          (clk),
        .rst          (rst),
        .new_read     (new_read),
        .ooo_evt      (ooo_evt),
        .miss_evt     (miss_evt),
        .seq_evt      (seq_evt),
        .burst_hint   (burst_hint),
        .first_pending(first_pending),
        .seq_flag     (seq_flag),
        .flag_nxt     (flag_nxt),
        .extend_evt   (extend_evt),
        .hit_set_evt  (hit_set_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_valid <= 1'b0;
            pend      <= 1'b0;
            pend_full <= 1'b0;
            first_q   <= 1'b0;
            drop      <= 1'b0;
            want_line <= 1'b0;
            free_q    <= 1'b0;
            win_base  <= '0;
            win_end   <= '0;
            last_addr <= '0;
            pend_addr <= '0;
        end else begin
            if (hit_set_evt)
                want_line <= 1'b1;
            if (act && (cls.seq || cls.ooo))
                last_addr <= req_addr;
            if (inval_now || miss_evt) begin
                buf_valid <= 1'b0;
                want_line <= 1'b0;
                free_q    <= 1'b0;
                if (pend)
                    drop <= 1'b1;
            end
            if (new_read) begin
                pend      <= 1'b1;
                pend_addr <= req_addr;
                pend_full <= 1'b0;
                first_q   <= 1'b1;
                drop      <= 1'b0;
                win_base  <= req_addr;
                win_end   <= req_addr;
                last_addr <= req_addr;
                want_line <= 1'b0;
                free_q    <= 1'b0;
            end else if (issue) begin
                pend      <= 1'b1;
                pend_addr <= win_end;
                pend_full <= flag_nxt;
                first_q   <= 1'b0;
                want_line <= 1'b0;
                free_q    <= 1'b0;
            end
            if (pend && fetch_ack) begin
                pend    <= 1'b0;
                first_q <= 1'b0;
                drop    <= 1'b0;
                if (!drop && !inval_now && !miss_evt) begin
                    buf_valid <= 1'b1;
                    win_end   <= pend_addr + {{PAD{1'b0}}, pend_len};
                end
            end
            if (extend_evt)
                pend_full <= 1'b1;
            if (line_free)
                free_q <= 1'b1;
        end
    end

    assign req_hit    = req_valid && cls.hit;
    assign fetch_req  = pend;
    assign fetch_addr = pend_addr;
    assign fetch_len  = pend_len;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_req,
    input logic          fetch_ack,
    input logic [AW-1:0] fetch_addr,
    input logic [5:0]    fetch_len,
    input logic          burst_hint,
    input logic          seq_flag,
    input logic          cyc_valid,
    input logic [2:0]    cyc_kind,
    input logic          buf_valid,
    input logic          ooo_evt
);
    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr)); // R3

    AST_LEN_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_len != 6'd0) && ((7'(fetch_addr[4:0]) + 7'(fetch_len)) <= 7'd32)); // R6

    AST_BURST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(burst_hint) |=> !seq_flag); // R9

    AST_WRITE_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && (cyc_kind == 3'd1 || cyc_kind == 3'd3) |=> !buf_valid); // R10

    AST_JUMP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ooo_evt |=> !seq_flag); // R7
endmodule

bind seq_prefetch_ctrl spc_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_req (fetch_req),
    .fetch_ack (fetch_ack),
    .fetch_addr(fetch_addr),
    .fetch_len (fetch_len),
    .burst_hint(burst_hint),
    .seq_flag  (seq_flag),
    .cyc_valid (cyc_valid),
    .cyc_kind  (cyc_kind),
    .buf_valid (buf_valid),
    .ooo_evt   (ooo_evt)
);

// File: tb/seq_prefetch_ctrl_bench.sv
module seq_prefetch_ctrl_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_hit;
    logic          burst_hint = 1'b0;
    logic          line_free = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [2:0]    cyc_kind = 3'd0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic [5:0]    fetch_len;
    logic          fetch_ack = 1'b0;
    logic          seq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seq_prefetch_ctrl #(.AW(AW)) u_seq_prefetch_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_hit(req_hit),
        .burst_hint(burst_hint), .line_free(line_free),
        .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_len(fetch_len),
        .fetch_ack(fetch_ack), .seq_flag(seq_flag)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(logic [AW-1:0] a);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic peek(string tag, logic [AW-1:0] a, logic exp);
        req_valid = 1'b1; req_addr = a;
        #1;
        chk(tag, 32'(req_hit), 32'(exp));
        req_valid = 1'b0;
    endtask

    task automatic do_ack();
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
    endtask

    task automatic do_free();
        line_free = 1'b1;
        @(negedge clk);
        line_free = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_cycle(logic [2:0] k);
        cyc_valid = 1'b1; cyc_kind = k;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    task automatic expect_fetch(string tag, logic [AW-1:0] a, logic [5:0] n);
        chk({tag, " fetch_req"}, 32'(fetch_req), 32'd1);
        chk({tag, " fetch_addr"}, fetch_addr, a);
        chk({tag, " fetch_len"}, 32'(fetch_len), 32'(n));
    endtask

    task automatic t_reset();
        chk("R1 fetch_req", 32'(fetch_req), 32'd0);
        chk("R1 seq_flag", 32'(seq_flag), 32'd0);
        peek("R1 req_hit", 32'h104, 1'b0);
    endtask

    task automatic t_new_read();
        do_req(32'h104);
        expect_fetch("R2", 32'h104, 6'd12);
        chk("R2 flag", 32'(seq_flag), 32'd0);
        @(negedge clk);
        expect_fetch("R3 held", 32'h104, 6'd12);
        do_ack();
        chk("R3 released", 32'(fetch_req), 32'd0);
        peek("R3 hit low", 32'h104, 1'b1);
        peek("R3 hit top", 32'h10C, 1'b1);
        peek("R3 past end", 32'h110, 1'b0);
        do_req(32'h104);
        chk("R3 repeat keeps flag", 32'(seq_flag), 32'd0);
    endtask

    task automatic t_seq_hit();
        do_req(32'h108);
        chk("R5 flag set", 32'(seq_flag), 32'd1);
        @(negedge clk);
        expect_fetch("R5 full line", 32'h110, 6'd16);
        do_ack();
        do_free();
        expect_fetch("R6 full", 32'h120, 6'd32);
        do_ack();
    endtask

    task automatic t_jump();
        do_req(32'h110);
        chk("R7 flag clear", 32'(seq_flag), 32'd0);
        do_free();
        expect_fetch("R6 half", 32'h140, 6'd16);
        do_ack();
        do_req(32'h114);
        chk("R5 flag again", 32'(seq_flag), 32'd1);
        @(negedge clk);
        expect_fetch("R5 second", 32'h150, 6'd16);
        do_ack();
    endtask

    task automatic t_burst_fall();
        burst_hint = 1'b1;
        @(negedge clk);
        burst_hint = 1'b0;
        @(negedge clk);
        chk("R9 flag clear", 32'(seq_flag), 32'd0);
    endtask

    task automatic t_inflight();
        do_free();
        expect_fetch("R11 issue", 32'h160, 6'd16);
        peek("R11 not hit", 32'h164, 1'b0);
        do_req(32'h164);
        expect_fetch("R11 kept", 32'h160, 6'd16);
        do_ack();
        peek("R11 data kept", 32'h164, 1'b1);
    endtask

    task automatic t_cycles();
        do_cycle(3'd0); do_cycle(3'd2); do_cycle(3'd4); do_cycle(3'd5); do_cycle(3'd6);
        peek("R10 reads keep data", 32'h164, 1'b1);
        do_cycle(3'd3);
        peek("R10 io write drops", 32'h164, 1'b0);
        do_req(32'h200);
        expect_fetch("R2 restart", 32'h200, 6'd16);
        do_ack();
        peek("R10 refill", 32'h204, 1'b1);
        do_cycle(3'd1);
        peek("R10 mem write drops", 32'h204, 1'b0);
    endtask

    task automatic t_burst_extend_and_miss();
        do_req(32'h208);
        expect_fetch("R4 before", 32'h208, 6'd8);
        chk("R4 flag before", 32'(seq_flag), 32'd0);
        burst_hint = 1'b1;
        @(negedge clk);
        chk("R4 flag", 32'(seq_flag), 32'd1);
        expect_fetch("R4 extended", 32'h208, 6'd24);
        do_ack();
        peek("R4 extended hit", 32'h21C, 1'b1);
        do_req(32'h300);
        chk("R8 flag clear", 32'(seq_flag), 32'd0);
        chk("R8 no fetch", 32'(fetch_req), 32'd0);
        peek("R8 data gone", 32'h208, 1'b0);
        burst_hint = 1'b0;
        @(negedge clk);
        do_req(32'h300);
        expect_fetch("R8 new read", 32'h300, 6'd16);
        chk("R8 flag after", 32'(seq_flag), 32'd0);
        do_ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_new_read();
        t_seq_hit();
        t_jump();
        t_burst_fall();
        t_inflight();
        t_cycles();
        t_burst_extend_and_miss();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule